// File: doc/BRIEF.md
# Invalidation Queue Descriptor Fetcher

This block consumes a circular command ring held in memory on behalf of an address-translation unit. Software places 128-bit invalidation descriptors in the ring and moves a tail pointer forward. The block fetches each descriptor from the head slot through a request/response memory port and checks its type code. It presents every supported descriptor on a valid/ready output and then moves the head forward, wrapping at the end of the ring. Executing the invalidations, completion signalling and interrupts belong to other blocks.

Configuration arrives through a single-cycle write port with three targets: the tail pointer, the ring address word (base address plus a size exponent) and a control word (enable and error clear). The ring holds 2^(code+8) entries and must sit on a boundary of its own byte size, so a fetch address is the base with the entry offset placed in the low bits. If a fetch returns a bus error or an unsupported type, the block halts with the head still pointing at the faulty slot. It stays halted until software clears the error, and then it fetches that slot again.

The controller is a five-state machine. IDLE goes to REQ when the block is enabled and the head differs from the masked tail. REQ goes to WAIT when the memory accepts the request. WAIT goes to SEND on a clean, supported response, or to HALT on an error response or an unsupported type. SEND goes back to IDLE when the consumer accepts the descriptor. HALT goes back to IDLE when software clears the error.

Top module: `inv_queue_fetcher`

## Requirements
- R1: After reset the head reads zero, the error flag is low, and neither mem_req_valid nor dsc_valid is asserted. Base, size code, tail and enable are all zero.
- R2: head_rd carries the head entry offset in bits 18:4, and all its other bits read as zero.
- R3: A fetch starts only when four conditions hold: enable is set, the head differs from the masked tail, no error is pending, and no descriptor is waiting downstream. At most one fetch is outstanding at any time. When the head equals the tail, no request is made.
- R4: The fetch address equals (base with bits 11:0 cleared) OR (head × 16).
- R5: A response is supported when it has no bus error and its type field (descriptor bits 3:0) holds a value from 1 to 5. A supported response is passed to dsc_data unchanged, and the head then advances by one.
- R6: The ring size code sits in bits 2:0 of the ring address word and gives 2^(code+8) entries. The head wraps from the last entry to zero.
- R7: The tail offset is written in bits 18:4 of the tail word. A tail value at or beyond the ring size is reduced modulo the ring size.
- R8: A bus error or an unsupported type moves the block to HALT. The head is left unchanged, nothing is sent downstream, and the error flag is raised. The flag and the head hold until a control write with bit 1 set, after which fetching resumes at the same slot.
- R9: A ring address word (base in bits 63:12) written while a fetch or hand-off is in progress is dropped. It is accepted only while the block is idle or halted.
- R10: Control bit 0 is the enable. While it is clear and the block is idle, the head is held at zero and no fetch starts.
- R11: A request is held, with a stable address, until mem_req_ready. A descriptor is held, with stable data, until dsc_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 tail, 1 ring address word, 2 control |
| cfg_wdata | input | 64 | Write data |
| head_rd | output | 64 | Head offset in bits 18:4, zero elsewhere |
| err_flag | output | 1 | Sticky fetch error, high while halted |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 128 | Returned descriptor |
| mem_rsp_err | input | 1 | Response carries a bus error |
| dsc_valid | output | 1 | Supported descriptor available |
| dsc_ready | input | 1 | Consumer takes the descriptor |
| dsc_data | output | 128 | Descriptor passed downstream |

## Verification
The main fetch path is exercised in four ways. A short run from head zero shows the basic order and addressing. Long runs that cross the end of the ring, at two size codes, separate a correct wrap from an off-by-one mask. A tail written above the ring size shows whether the block masks it or runs past it. Random rounds, with random base, size, tail step and back-pressure on both handshakes, show that neither stall lengths nor response delays alter the sequence. Directed faults inject an unsupported type code and, separately, a bus error at a known slot. These show a halted head apart from one that moves on. A ring address write made during a held request shows whether it is dropped or applied.

// File: rtl/ivq_pkg.sv
package ivq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_SEND,
        ST_HALT
    } ivq_state_e;

    localparam logic [1:0] SEL_TAIL  = 2'd0;
    localparam logic [1:0] SEL_QADDR = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

endpackage

// File: rtl/ivq_regs.sv
module ivq_regs
    import ivq_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int SIZE_W   = 3,
    parameter int MIN_EXP  = 8,
    parameter int BASE_LSB = 12,
    parameter int OFF_LSB  = 4,
    parameter int PTR_W    = MIN_EXP + (1 << SIZE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cfg_idle,
    output logic [ADDR_W-1:0] base_addr,
    output logic [PTR_W-1:0]  ptr_mask,
    output logic [PTR_W-1:0]  tail_eff,
    output logic              enable,
    output logic              clr_err
);
    localparam int BASE_W = ADDR_W - BASE_LSB;

    logic [BASE_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic [PTR_W-1:0]  tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            tail_q <= '0;
            enable <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_TAIL) begin
                tail_q <= cfg_wdata[OFF_LSB +: PTR_W];
            end
            if (cfg_sel == SEL_QADDR && cfg_idle) begin
                base_q <= cfg_wdata[ADDR_W-1:BASE_LSB];
                size_q <= cfg_wdata[SIZE_W-1:0];
            end
            if (cfg_sel == SEL_CTRL) begin
                enable <= cfg_wdata[CTRL_EN_BIT];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            ptr_mask[i] = (i < (int'(size_q) + MIN_EXP));
        end
    end

    assign tail_eff  = tail_q & ptr_mask;
    assign base_addr = {base_q, {BASE_LSB{1'b0}}};
    assign clr_err   = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_CLR_BIT];

endmodule

// File: rtl/ivq_ctrl.sv
module ivq_ctrl
    import ivq_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 128,
    parameter int PTR_W    = 15,
    parameter int OFF_LSB  = 4,
    parameter int TYPE_W   = 4,
    parameter int TYPE_MIN = 1,
    parameter int TYPE_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              clr_err,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [PTR_W-1:0]  ptr_mask,
    input  logic [PTR_W-1:0]  tail_eff,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              dsc_valid,
    input  logic              dsc_ready,
    output logic [DATA_W-1:0] dsc_data,
    output logic [PTR_W-1:0]  head,
    output logic              err_flag,
    output logic              cfg_idle
);
    ivq_state_e state, state_nxt;
    logic       rsp_good;
    logic [TYPE_W-1:0] rsp_type;

    assign rsp_type = mem_rsp_data[TYPE_W-1:0];
    assign rsp_good = !mem_rsp_err
                   && (rsp_type >= TYPE_W'(TYPE_MIN))
                   && (rsp_type <= TYPE_W'(TYPE_MAX));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (enable && (head != tail_eff))   state_nxt = ST_REQ;
            ST_REQ:  if (mem_req_ready)                  state_nxt = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid)                  state_nxt = rsp_good ? ST_SEND : ST_HALT;
            ST_SEND: if (dsc_ready)                      state_nxt = ST_IDLE;
            ST_HALT: if (clr_err)                        state_nxt = ST_IDLE;
            default:                                     state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = (state == ST_REQ);
        dsc_valid     = (state == ST_SEND);
        err_flag      = (state == ST_HALT);
        cfg_idle      = (state == ST_IDLE) || (state == ST_HALT);
        mem_req_addr  = base_addr | (ADDR_W'(head) << OFF_LSB);
    end

    // head pointer and captured descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head     <= '0;
            dsc_data <= '0;
        end else begin
            if (state == ST_IDLE) begin
                head <= enable ? (head & ptr_mask) : '0;
            end
            if (state == ST_WAIT && mem_rsp_valid && rsp_good) begin
                head     <= (head + 1'b1) & ptr_mask;
                dsc_data <= mem_rsp_data;
            end
        end
    end

endmodule

// File: rtl/inv_queue_fetcher.sv
module inv_queue_fetcher
    import ivq_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 128,
    parameter int SIZE_W   = 3,
    parameter int MIN_EXP  = 8,
    parameter int TYPE_W   = 4,
    parameter int TYPE_MIN = 1,
    parameter int TYPE_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] head_rd,
    output logic              err_flag,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              dsc_valid,
    input  logic              dsc_ready,
    output logic [DATA_W-1:0] dsc_data
);
    localparam int OFF_LSB  = $clog2(DATA_W / 8);
    localparam int BASE_LSB = 12;
    localparam int PTR_W    = MIN_EXP + (1 << SIZE_W) - 1;

    logic [ADDR_W-1:0] base_addr;
    logic [PTR_W-1:0]  ptr_mask, tail_eff, head;
    logic              enable, clr_err, cfg_idle;

    ivq_regs #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MIN_EXP(MIN_EXP),
        .BASE_LSB(BASE_LSB), .OFF_LSB(OFF_LSB), .PTR_W(PTR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_idle(cfg_idle),
        .base_addr(base_addr), .ptr_mask(ptr_mask), .tail_eff(tail_eff),
        .enable(enable), .clr_err(clr_err)
    );

    ivq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .OFF_LSB(OFF_LSB),
        .TYPE_W(TYPE_W), .TYPE_MIN(TYPE_MIN), .TYPE_MAX(TYPE_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .enable(enable), .clr_err(clr_err),
        .base_addr(base_addr), .ptr_mask(ptr_mask), .tail_eff(tail_eff),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_data(dsc_data),
        .head(head), .err_flag(err_flag), .cfg_idle(cfg_idle)
    );

    assign head_rd = ADDR_W'(head) << OFF_LSB;

endmodule

// File: rtl/ivq_checker.sv
module ivq_checker #(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 128,
    parameter int TYPE_W   = 4,
    parameter int TYPE_MIN = 1,
    parameter int TYPE_MAX = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic [ADDR_W-1:0] head_rd,
    input logic              err_flag,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [DATA_W-1:0] mem_rsp_data,
    input logic              mem_rsp_err,
    input logic              dsc_valid,
    input logic              dsc_ready,
    input logic [DATA_W-1:0] dsc_data
);
    logic clr_wr;
    assign clr_wr = cfg_we && (cfg_sel == 2'd2) && cfg_wdata[1];

    p_head_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (head_rd[3:0] == 4'h0) && (head_rd[ADDR_W-1:19] == '0));

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_no_fetch_while_sending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid |-> !mem_req_valid);

    p_type_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid |-> (dsc_data[TYPE_W-1:0] >= TYPE_W'(TYPE_MIN))
                   && (dsc_data[TYPE_W-1:0] <= TYPE_W'(TYPE_MAX)));

    p_halt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_wr) |=> (err_flag && $stable(head_rd)));

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!mem_req_valid && !dsc_valid));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_dsc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_data)));

endmodule

bind inv_queue_fetcher ivq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TYPE_W(TYPE_W),
    .TYPE_MIN(TYPE_MIN), .TYPE_MAX(TYPE_MAX)
) u_chk (.*);

// File: tb/inv_queue_fetcher_test.sv
`timescale 1ns/1ps
module inv_queue_fetcher_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = 2'd0;
    logic [63:0]  cfg_wdata = '0;
    logic [63:0]  head_rd;
    logic         err_flag;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic         mem_rsp_err = 1'b0;
    logic         dsc_valid;
    logic         dsc_ready = 1'b0;
    logic [127:0] dsc_data;

    always #4 clk = ~clk;

    inv_queue_fetcher uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .head_rd(head_rd), .err_flag(err_flag),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_data(dsc_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [63:0]  base_m = '0;
    int           size_m = 0;
    int           tail_m = 0;
    int           hd_m = 0;
    int           bad_idx = -1;
    int           err_idx = -1;
    bit           hold_req = 0;
    bit           pending = 0;
    int           delay = 0;
    int           cur_idx = 0;
    logic [63:0]  cur_addr = '0;
    int           n_rcv = 0;
    logic [127:0] exp_q[$];

    initial void'($urandom(32'd1357));

    function automatic int mask_of(int sz);
        return (1 << (sz + 8)) - 1;
    endfunction

    function automatic logic [127:0] desc_fn(logic [63:0] a);
        logic [3:0] t;
        t = 4'(1 + (a[7:4] % 5));
        return {a ^ 64'h5a5a_0f0f_3c3c_9696, a[63:4], t};
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_tail(int t);
        tail_m = t;
        cfg_write(2'd0, 64'(t) << 4);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (err_flag && !pending && !mem_rsp_valid) break;
            if (!pending && !mem_rsp_valid && !mem_req_valid && !dsc_valid
                && exp_q.size() == 0 && int'(head_rd[18:4]) == (tail_m & mask_of(size_m)))
                break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet_window(string req, int cycles);
        bit seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (mem_req_valid) seen = 1;
        end
        check(!seen, req, 128'(seen), 128'(0));
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
            if (pending) begin
                mem_req_ready = 1'b0;
                if (delay == 0) begin
                    pending = 0;
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = desc_fn(cur_addr);
                    mem_rsp_err   = 1'b0;
                    if (cur_idx == err_idx) begin
                        mem_rsp_err = 1'b1;
                    end else if (cur_idx == bad_idx) begin
                        mem_rsp_data[3:0] = (cur_idx % 2 == 0) ? 4'h0 : 4'hC;
                    end else begin
                        exp_q.push_back(mem_rsp_data);
                        hd_m = (hd_m + 1) & mask_of(size_m);
                    end
                end else begin
                    delay--;
                end
            end else begin
                mem_req_ready = hold_req ? 1'b0 : ($urandom % 4 != 0);
                if (mem_req_valid && mem_req_ready) begin
                    // R4: address built from base and head offset
                    check(mem_req_addr == (base_m | (64'(hd_m) << 4)), "R4 fetch address",
                          128'(mem_req_addr), 128'(base_m | (64'(hd_m) << 4)));
                    cur_addr = mem_req_addr;
                    cur_idx  = hd_m;
                    pending  = 1;
                    delay    = $urandom % 3;
                end
            end
        end
    end

    // downstream consumer
    initial begin
        forever begin
            @(negedge clk);
            dsc_ready = ($urandom % 3 != 0);
            if (dsc_valid && dsc_ready) begin
                n_rcv++;
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected descriptor", dsc_data, 128'(0));
                end else begin
                    logic [127:0] e;
                    e = exp_q.pop_front();
                    check(dsc_data == e, "R5 descriptor data", dsc_data, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(head_rd == 64'h0, "R1 head at reset", 128'(head_rd), 128'(0));
        check(!err_flag && !mem_req_valid && !dsc_valid, "R1 outputs idle at reset",
              128'({err_flag, mem_req_valid, dsc_valid}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(head_rd == 64'h0 && !mem_req_valid, "R1 after release",
              128'(head_rd), 128'(0));

        // basic run
        base_m = 64'h0000_0000_8000_0000; size_m = 0;
        cfg_write(2'd1, base_m | 64'd0);
        cfg_write(2'd2, 64'h1);
        set_tail(5);
        wait_drain();
        check(head_rd == (64'd5 << 4), "R2 head after five fetches", 128'(head_rd), 128'(64'd5 << 4));
        check(n_rcv == 5, "R3 five descriptors delivered", 128'(n_rcv), 128'(5));
        quiet_window("R3 no fetch when head equals tail", 30);

        // wrap with oversize tail: 0x103 masks to 3 for a 256-entry ring
        r0 = n_rcv;
        set_tail(32'h103);
        wait_drain();
        check(head_rd == (64'd3 << 4), "R7 tail masked to ring size", 128'(head_rd), 128'(64'd3 << 4));
        check(n_rcv - r0 == 254, "R6 wrap through slot 255 to 0", 128'(n_rcv - r0), 128'(254));

        // unsupported type at slot 6
        bad_idx = 6; r0 = n_rcv;
        set_tail(10);
        wait_drain();
        check(err_flag == 1'b1, "R8 halt on unsupported type", 128'(err_flag), 128'(1));
        check(head_rd == (64'd6 << 4), "R8 head held at bad slot", 128'(head_rd), 128'(64'd6 << 4));
        check(n_rcv - r0 == 3, "R8 nothing passed from bad slot", 128'(n_rcv - r0), 128'(3));
        quiet_window("R8 no fetch while halted", 25);
        check(head_rd == (64'd6 << 4) && err_flag, "R8 state sticky", 128'(head_rd), 128'(64'd6 << 4));
        bad_idx = -1;
        cfg_write(2'd2, 64'h3);
        wait_drain();
        check(!err_flag && head_rd == (64'd10 << 4), "R8 resume after clear",
              128'({err_flag, head_rd}), 128'(64'd10 << 4));

        // bus error at slot 12
        err_idx = 12;
        set_tail(14);
        wait_drain();
        check(err_flag && head_rd == (64'd12 << 4), "R8 halt on bus error",
              128'({err_flag, head_rd}), 128'({1'b1, 64'd12 << 4}));
        err_idx = -1;
        cfg_write(2'd2, 64'h3);
        wait_drain();
        check(!err_flag && head_rd == (64'd14 << 4), "R8 resume after bus error",
              128'({err_flag, head_rd}), 128'(64'd14 << 4));

        // ring address write while a request is held
        hold_req = 1;
        set_tail(16);
        for (int i = 0; i < 50 && !mem_req_valid; i++) @(negedge clk);
        cfg_write(2'd1, 64'h0000_0000_9000_0000 | 64'd1);
        hold_req = 0;
        wait_drain();
        check(head_rd == (64'd16 << 4), "R9 run finished with old ring", 128'(head_rd), 128'(64'd16 << 4));
        r0 = n_rcv;
        set_tail(272);   // 272 mod 256 = 16 if the size change was dropped
        quiet_window("R9 size write during fetch dropped", 30);
        check(head_rd == (64'd16 << 4) && n_rcv == r0, "R9 head unchanged", 128'(head_rd), 128'(64'd16 << 4));

        // accepted while idle: 512 entries at new base
        base_m = 64'h0000_0000_9000_0000; size_m = 1;
        cfg_write(2'd1, base_m | 64'd1);
        wait_drain();
        check(head_rd == (64'd272 << 4), "R6 size code 1 accepted", 128'(head_rd), 128'(64'd272 << 4));
        r0 = n_rcv;
        set_tail(2);
        wait_drain();
        check(head_rd == (64'd2 << 4) && n_rcv - r0 == 242, "R6 wrap at slot 511",
              128'(n_rcv - r0), 128'(242));

        // disable
        cfg_write(2'd2, 64'h0);
        hd_m = 0;
        repeat (3) @(negedge clk);
        check(head_rd == 64'h0, "R10 head cleared when disabled", 128'(head_rd), 128'(0));
        quiet_window("R10 no fetch while disabled", 30);
        cfg_write(2'd2, 64'h1);
        wait_drain();
        check(head_rd == (64'd2 << 4), "R10 restart from zero", 128'(head_rd), 128'(64'd2 << 4));

        // random rounds
        for (int k = 0; k < 20; k++) begin
            int step;
            size_m = $urandom % 3;
            base_m = {$urandom, $urandom} & ~64'h7FFF;
            cfg_write(2'd1, base_m | 64'(size_m));
            hd_m = hd_m & mask_of(size_m);
            step = 1 + ($urandom % 60);
            r0 = n_rcv;
            set_tail((hd_m + step) & mask_of(size_m));
            wait_drain();
            check(int'(head_rd[18:4]) == tail_m, "R5 random round head",
                  128'(head_rd[18:4]), 128'(tail_m));
            check(n_rcv - r0 == step, "R3 random round count", 128'(n_rcv - r0), 128'(step));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule